// File: doc/BRIEF.md
# Vectored Interrupt Controller with Flag Semantics

This block arbitrates interrupt requests for a small processor core. It holds one flag and one enable bit for each source, plus a global maskable-interrupt enable (GIE). There are three source groups. The first is three non-maskable-class sources (external pin, clock fault, memory access violation), which share one vector. The second is `NS` single-source maskable sources, each with its own vector. The third is a group of `NM` multi-source maskable sources, which share the lowest-priority vector.

Flags are set by hardware events or by software. Flags are cleared by software, and single-source flags are also cleared automatically when their vector is taken. Each cycle the block evaluates the pending requests and registers the winning vector index. The core takes that vector with an acknowledge strobe and ends the handler with a return strobe.

An acknowledge does three things:
- it clears GIE;
- it pushes the previous GIE value onto an internal stack, which is 8 entries deep by default;
- if the vector is the non-maskable-class vector, it clears all three non-maskable-class enables.

A return pops the stack and restores GIE.

The vector output works as a valid/ready pair, with `irq_ack` acting as ready. A vector is taken only in a cycle where `irq_valid` and `irq_ack` are both high. While the core holds off, the request stays pending in the flags, so nothing is lost. The registered vector index may change to a newly winning source before it is taken. The cycle after a take, `irq_valid` is low.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, all flags, all enables, GIE, `irq_valid` and `stk_ovf` are 0.
- R2: A hardware event sets its flag in the next cycle, whatever the enables or GIE are. An event wins over a software clear or an automatic clear in the same cycle.
- R3: Software can set or clear any flag through `sw_flag_set`/`sw_flag_clr`. A software-set flag requests exactly like an event. A flag that is cleared before its enable is set never requests.
- R4: Flag bits 0..2 are the non-maskable-class sources. Each one requests vector 0 when its flag and its enable are both 1, whatever GIE is.
- R5: A maskable source requests only when its flag, its enable and GIE are all 1.
- R6: Single-source flag `3+k` maps to vector `1+k`. Multi-source flags `3+NS .. 3+NS+NM-1` map to vector `NS+1`. When several requests are pending, the lowest vector index wins.
- R7: `irq_valid`/`irq_vec` show the requests of the previous cycle. After a take, `irq_valid` is 0 in the next cycle. `irq_ack` while `irq_valid` is 0 has no effect.
- R8: Taking vector `1+k` clears flag `3+k`. An event that recurs afterwards sets it again, and it stays set until software clears it.
- R9: Taking the non-maskable-class vector or the multi-source vector never clears a flag. A flag left set requests again once GIE is restored by return.
- R10: Taking vector 0 clears enable bits 0..2. They stay 0 across returns until software writes them.
- R11: A take clears GIE and pushes its previous value. A return restores the most recently pushed value. A return with an empty stack leaves GIE unchanged. `irq_ack` takes precedence over `irq_ret`, and both take precedence over a software GIE write in the same cycle.
- R12: A take while the stack holds `DEPTH` entries drops that entry and sets `stk_ovf`, which stays set until reset.
- R13: Maskable enable bits change only through a software enable write, never through a take or a return.
- R14: Nesting is not limited by priority. If software sets GIE inside a handler, the same or a lower-priority source is taken again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_nmi | input | 3 | Non-maskable-class event pulses (pin, clock fault, access violation) |
| evt_single | input | NS | Single-source event pulses |
| evt_multi | input | NM | Multi-source group event pulses |
| sw_flag_set | input | 3+NS+NM | Software flag set, one bit per flag |
| sw_flag_clr | input | 3+NS+NM | Software flag clear, one bit per flag |
| sw_en_wr | input | 1 | Enable register write strobe |
| sw_en_data | input | 3+NS+NM | Enable register write value |
| sw_gie_wr | input | 1 | GIE write strobe |
| sw_gie_data | input | 1 | GIE write value |
| irq_ack | input | 1 | Take strobe (ready) |
| irq_ret | input | 1 | Return-from-handler strobe |
| irq_valid | output | 1 | A vector is pending |
| irq_vec | output | clog2(NS+2) | Winning vector index |
| gie | output | 1 | Global maskable enable |
| flags | output | 3+NS+NM | Flag register |
| enables | output | 3+NS+NM | Enable register |
| stk_ovf | output | 1 | Sticky saved-GIE stack overflow |

## Verification
The assertions assume that `rst_n` is held low until the first edge, and that enable writes reach the maskable bits only through `sw_en_wr`. They also assume that `irq_ret` pulses only for a handler that was actually taken, except for the single deliberate empty-stack return. The stimulus drives every input just after a falling edge and pulses the strobes for exactly one cycle. It raises `irq_ack` only after it has seen `irq_valid` high, so that each take refers to a known vector. The sweep reprograms the whole state before each pattern, so no stale request carries over between patterns.

// File: rtl/irq_vc_pkg.sv
package irq_vc_pkg;
  localparam int NMI_SRCS = 3;

  typedef enum logic [1:0] {
    SRC_NMI    = 2'd0,
    SRC_SINGLE = 2'd1,
    SRC_MULTI  = 2'd2
  } src_kind_e;

  // Flag index layout: [0..2] non-maskable class, then single, then multi group
  function automatic src_kind_e kind_of(input int idx, input int ns);
    if (idx < NMI_SRCS) return SRC_NMI;
    if (idx < NMI_SRCS + ns) return SRC_SINGLE;
    return SRC_MULTI;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_vc_pkg::*;
#(
  parameter int NS = 4,
  parameter int NM = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NMI_SRCS+NS+NM-1:0]             evt,
  input  logic [NMI_SRCS+NS+NM-1:0]             sw_set,
  input  logic [NMI_SRCS+NS+NM-1:0]             sw_clr,
  input  logic                                  en_wr,
  input  logic [NMI_SRCS+NS+NM-1:0]             en_data,
  input  logic                                  ack_fire,
  input  logic [$clog2(NS+2)-1:0]               ack_vec,
  output logic [NMI_SRCS+NS+NM-1:0]             flags,
  output logic [NMI_SRCS+NS+NM-1:0]             enables
);
  localparam int N  = NMI_SRCS + NS + NM;
  localparam int VW = $clog2(NS + 2);

  logic nmi_take;
  assign nmi_take = ack_fire && (ack_vec == '0);

  for (genvar i = 0; i < N; i++) begin : g_src
    localparam src_kind_e KIND = kind_of(i, NS);
    logic auto_clr;
    logic f_q;
    logic e_q;

    if (KIND == SRC_SINGLE) begin : g_auto
      assign auto_clr = ack_fire && (ack_vec == VW'(i - NMI_SRCS + 1));
    end else begin : g_keep
      assign auto_clr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f_q <= 1'b0;
      else        f_q <= evt[i] | sw_set[i] | (f_q & ~sw_clr[i] & ~auto_clr);
    end

    if (KIND == SRC_NMI) begin : g_en_nmi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        e_q <= 1'b0;
        else if (nmi_take) e_q <= 1'b0;
        else if (en_wr)    e_q <= en_data[i];
      end
    end else begin : g_en_mask
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     e_q <= 1'b0;
        else if (en_wr) e_q <= en_data[i];
      end
    end

    assign flags[i]   = f_q;
    assign enables[i] = e_q;
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_vc_pkg::*;
#(
  parameter int NS = 4,
  parameter int NM = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NMI_SRCS+NS+NM-1:0]     flags,
  input  logic [NMI_SRCS+NS+NM-1:0]     enables,
  input  logic                          gie,
  input  logic                          ack_fire,
  output logic                          irq_valid,
  output logic [$clog2(NS+2)-1:0]       irq_vec
);
  localparam int NV    = NS + 2;
  localparam int VW    = $clog2(NV);
  localparam int MS_LO = NMI_SRCS + NS;

  logic [NV-1:0] req;
  logic [VW-1:0] pick;

  always_comb begin
    req[0] = |(flags[NMI_SRCS-1:0] & enables[NMI_SRCS-1:0]);
    for (int k = 0; k < NS; k++)
      req[1+k] = gie & flags[NMI_SRCS+k] & enables[NMI_SRCS+k];
    req[NV-1] = gie & (|(flags[MS_LO +: NM] & enables[MS_LO +: NM]));
  end

  always_comb begin
    pick = '0;
    for (int v = NV - 1; v >= 0; v--)
      if (req[v]) pick = VW'(v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_vec   <= '0;
    end else begin
      irq_valid <= ack_fire ? 1'b0 : (|req);
      irq_vec   <= pick;
    end
  end
endmodule

// File: rtl/irq_gie_stack.sv
module irq_gie_stack #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_fire,
  input  logic ret,
  input  logic sw_wr,
  input  logic sw_data,
  output logic gie,
  output logic stk_ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int DW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] stk;
  logic [DW-1:0]    depth;
  logic             full;
  logic             empty;

  assign full  = (depth == DW'(DEPTH));
  assign empty = (depth == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie     <= 1'b0;
      stk     <= '0;
      depth   <= '0;
      stk_ovf <= 1'b0;
    end else if (ack_fire) begin
      gie <= 1'b0;
      if (full) begin
        stk_ovf <= 1'b1;
      end else begin
        stk[AW'(depth)] <= gie;
        depth           <= depth + 1'b1;
      end
    end else if (ret) begin
      if (!empty) begin
        gie   <= stk[AW'(depth - 1'b1)];
        depth <= depth - 1'b1;
      end
    end else if (sw_wr) begin
      gie <= sw_data;
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vc_pkg::*;
#(
  parameter int NS    = 4,
  parameter int NM    = 3,
  parameter int DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NMI_SRCS-1:0]           evt_nmi,
  input  logic [NS-1:0]                 evt_single,
  input  logic [NM-1:0]                 evt_multi,
  input  logic [NMI_SRCS+NS+NM-1:0]     sw_flag_set,
  input  logic [NMI_SRCS+NS+NM-1:0]     sw_flag_clr,
  input  logic                          sw_en_wr,
  input  logic [NMI_SRCS+NS+NM-1:0]     sw_en_data,
  input  logic                          sw_gie_wr,
  input  logic                          sw_gie_data,
  input  logic                          irq_ack,
  input  logic                          irq_ret,
  output logic                          irq_valid,
  output logic [$clog2(NS+2)-1:0]       irq_vec,
  output logic                          gie,
  output logic [NMI_SRCS+NS+NM-1:0]     flags,
  output logic [NMI_SRCS+NS+NM-1:0]     enables,
  output logic                          stk_ovf
);
  localparam int N = NMI_SRCS + NS + NM;

  logic [N-1:0] evt_all;
  logic         ack_fire;

  assign evt_all  = {evt_multi, evt_single, evt_nmi};
  assign ack_fire = irq_ack & irq_valid;

  irq_flag_bank #(.NS(NS), .NM(NM)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_all),
    .sw_set   (sw_flag_set),
    .sw_clr   (sw_flag_clr),
    .en_wr    (sw_en_wr),
    .en_data  (sw_en_data),
    .ack_fire (ack_fire),
    .ack_vec  (irq_vec),
    .flags    (flags),
    .enables  (enables)
  );

  irq_prio_arb #(.NS(NS), .NM(NM)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags     (flags),
    .enables   (enables),
    .gie       (gie),
    .ack_fire  (ack_fire),
    .irq_valid (irq_valid),
    .irq_vec   (irq_vec)
  );

  irq_gie_stack #(.DEPTH(DEPTH)) u_gie (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_fire (ack_fire),
    .ret      (irq_ret),
    .sw_wr    (sw_gie_wr),
    .sw_data  (sw_gie_data),
    .gie      (gie),
    .stk_ovf  (stk_ovf)
  );
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
  import irq_vc_pkg::*;
#(
  parameter int NS = 4,
  parameter int NM = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NMI_SRCS-1:0]           evt_nmi,
  input logic [NS-1:0]                 evt_single,
  input logic [NM-1:0]                 evt_multi,
  input logic [NMI_SRCS+NS+NM-1:0]     sw_flag_set,
  input logic [NMI_SRCS+NS+NM-1:0]     sw_flag_clr,
  input logic                          sw_en_wr,
  input logic                          irq_ack,
  input logic                          irq_valid,
  input logic [$clog2(NS+2)-1:0]       irq_vec,
  input logic                          gie,
  input logic [NMI_SRCS+NS+NM-1:0]     flags,
  input logic [NMI_SRCS+NS+NM-1:0]     enables,
  input logic                          stk_ovf
);
  localparam int N     = NMI_SRCS + NS + NM;
  localparam int MS_LO = NMI_SRCS + NS;

  logic         ack_fire;
  logic [N-1:0] evt_all;
  logic [N-1:0] sel_mask;

  assign ack_fire = irq_ack & irq_valid;
  assign evt_all  = {evt_multi, evt_single, evt_nmi};

  always_comb begin
    sel_mask = '0;
    if (ack_fire && irq_vec >= 1 && int'(irq_vec) <= NS)
      sel_mask = N'(1) << (int'(irq_vec) + NMI_SRCS - 1);
  end

  assert_vec_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> int'(irq_vec) <= NS + 1);

  assert_valid_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !irq_valid);

  assert_mask_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_vec != '0) |-> $past(gie));

  assert_single_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|sel_mask) && ((sel_mask & (evt_all | sw_flag_set)) == '0))
      |=> ((flags & $past(sel_mask)) == '0));

  assert_multi_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (($past(flags[MS_LO +: NM]) & ~$past(sw_flag_clr[MS_LO +: NM])
                   & ~flags[MS_LO +: NM]) == '0));

  assert_nmi_en_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && irq_vec == '0) |=> (enables[NMI_SRCS-1:0] == '0));

  assert_gie_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !gie);

  assert_ovf_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |=> stk_ovf);

  assert_mask_en_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en_wr |=> (enables[N-1:NMI_SRCS] == $past(enables[N-1:NMI_SRCS])));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.NS(NS), .NM(NM)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_nmi     (evt_nmi),
  .evt_single  (evt_single),
  .evt_multi   (evt_multi),
  .sw_flag_set (sw_flag_set),
  .sw_flag_clr (sw_flag_clr),
  .sw_en_wr    (sw_en_wr),
  .irq_ack     (irq_ack),
  .irq_valid   (irq_valid),
  .irq_vec     (irq_vec),
  .gie         (gie),
  .flags       (flags),
  .enables     (enables),
  .stk_ovf     (stk_ovf)
);

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
  localparam int NS = 4;
  localparam int NM = 3;
  localparam int DEPTH = 8;
  localparam int N = 3 + NS + NM;
  localparam int VW = $clog2(NS + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] evt_nmi = '0;
  logic [NS-1:0] evt_single = '0;
  logic [NM-1:0] evt_multi = '0;
  logic [N-1:0] sw_flag_set = '0, sw_flag_clr = '0, sw_en_data = '0;
  logic sw_en_wr = 1'b0, sw_gie_wr = 1'b0, sw_gie_data = 1'b0;
  logic irq_ack = 1'b0, irq_ret = 1'b0;
  logic irq_valid, gie, stk_ovf;
  logic [VW-1:0] irq_vec;
  logic [N-1:0] flags, enables;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_vec_ctrl #(.NS(NS), .NM(NM), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_nmi(evt_nmi), .evt_single(evt_single),
    .evt_multi(evt_multi), .sw_flag_set(sw_flag_set), .sw_flag_clr(sw_flag_clr),
    .sw_en_wr(sw_en_wr), .sw_en_data(sw_en_data), .sw_gie_wr(sw_gie_wr),
    .sw_gie_data(sw_gie_data), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .gie(gie), .flags(flags),
    .enables(enables), .stk_ovf(stk_ovf));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic int exp_vec(input logic [N-1:0] f, input logic [N-1:0] e, input logic g);
    if (|(f[2:0] & e[2:0])) return 0;
    for (int k = 0; k < NS; k++) if (g && f[3+k] && e[3+k]) return 1 + k;
    if (g && (|(f[3+NS +: NM] & e[3+NS +: NM]))) return NS + 1;
    return -1;
  endfunction

  task automatic set_state(input logic [N-1:0] f, input logic [N-1:0] e, input logic g);
    sw_flag_clr = '1; sw_en_wr = 1'b1; sw_en_data = e; sw_gie_wr = 1'b1; sw_gie_data = g;
    cyc();
    sw_flag_clr = '0; sw_en_wr = 1'b0; sw_gie_wr = 1'b0; sw_flag_set = f;
    cyc();
    sw_flag_set = '0;
    cyc();
  endtask

  task automatic take();
    irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
  endtask

  task automatic give_back();
    irq_ret = 1'b1; cyc(); irq_ret = 1'b0;
  endtask

  task automatic gie_write(input logic v);
    sw_gie_wr = 1'b1; sw_gie_data = v; cyc(); sw_gie_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] msk;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 flags", int'(flags), 0);
    chk("R1 enables", int'(enables), 0);
    chk("R1 gie", int'(gie), 0);
    chk("R1 valid", int'(irq_valid), 0);
    chk("R1 ovf", int'(stk_ovf), 0);

    // R3 R4 R5 R6: sweep every flag pattern with varied enables and GIE
    for (int p = 0; p < (1 << N); p++) begin
      logic [N-1:0] e;
      logic g;
      int ev;
      e = p[0] ? '1 : N'((p * 7 + 3) ^ (p >> 2));
      g = p[1] ^ p[4];
      set_state(N'(p), e, g);
      ev = exp_vec(N'(p), e, g);
      chk("R3 sw set", int'(flags), p);
      chk("R5 R4 valid", int'(irq_valid), (ev >= 0) ? 1 : 0);
      if (ev >= 0) chk("R6 vec", int'(irq_vec), ev);
    end

    // R2 event sets flag while disabled
    set_state('0, '0, 1'b1);
    evt_single[1] = 1'b1; cyc(); evt_single[1] = 1'b0; cyc();
    chk("R2 evt sets", int'(flags[4]), 1);
    chk("R2 no req", int'(irq_valid), 0);
    // R2 event beats clear in same cycle
    evt_single[1] = 1'b1; sw_flag_clr[4] = 1'b1; cyc();
    evt_single[1] = 1'b0; sw_flag_clr[4] = 1'b0;
    chk("R2 evt wins", int'(flags[4]), 1);
    // R3 cleared before enabling never requests
    sw_flag_clr[4] = 1'b1; cyc(); sw_flag_clr[4] = 1'b0;
    sw_en_wr = 1'b1; sw_en_data = N'(1) << 4; cyc(); sw_en_wr = 1'b0;
    cyc();
    chk("R3 cleared no req", int'(irq_valid), 0);

    // R4 R10 non-maskable class with GIE off
    set_state(N'(3'b010), '1, 1'b0);
    chk("R4 valid", int'(irq_valid), 1);
    chk("R4 vec0", int'(irq_vec), 0);
    take();
    chk("R10 nmi en cleared", int'(enables[2:0]), 0);
    chk("R9 nmi flag kept", int'(flags[1]), 1);
    chk("R11 gie off", int'(gie), 0);
    chk("R7 valid drop", int'(irq_valid), 0);
    cyc();
    chk("R10 no re-req", int'(irq_valid), 0);
    give_back();
    chk("R11 gie restored 0", int'(gie), 0);
    chk("R10 en stay off", int'(enables[2:0]), 0);
    chk("R13 mask en kept", int'(enables[N-1:3]), (1 << (N - 3)) - 1);

    // R8 single-source auto clear and recurrence
    msk = '1; msk[2:0] = '0;
    set_state(N'(1) << 3, msk, 1'b1);
    chk("R8 vec1", int'(irq_vec), 1);
    take();
    chk("R8 flag cleared", int'(flags[3]), 0);
    chk("R13 en after take", int'(enables), int'(msk));
    evt_single[0] = 1'b1; cyc(); evt_single[0] = 1'b0;
    chk("R8 recur stays", int'(flags[3]), 1);
    cyc();
    chk("R5 gie off no req", int'(irq_valid), 0);
    give_back();
    chk("R11 gie back", int'(gie), 1);
    cyc();
    chk("R8 re-request", int'(irq_valid), 1);
    chk("R13 en after ret", int'(enables), int'(msk));

    // R9 multi-source stays set, re-requests after return
    set_state(N'(1) << (3 + NS), msk, 1'b1);
    chk("R6 multi vec", int'(irq_vec), NS + 1);
    take();
    chk("R9 multi kept", int'(flags[3+NS]), 1);
    cyc();
    chk("R9 quiet in handler", int'(irq_valid), 0);
    give_back(); cyc();
    chk("R9 re-request", int'(irq_valid), 1);
    chk("R9 vec", int'(irq_vec), NS + 1);

    // R14 nesting of the same lowest-priority source
    take();
    gie_write(1'b1); cyc();
    chk("R14 nested valid", int'(irq_valid), 1);
    chk("R14 nested vec", int'(irq_vec), NS + 1);
    take();
    give_back();
    chk("R11 inner ret", int'(gie), 1);
    give_back();
    chk("R11 outer ret", int'(gie), 1);

    // R7 ack without valid is ignored
    set_state('0, '1, 1'b1);
    take();
    chk("R7 ignored ack", int'(gie), 1);

    // R12 overflow of saved-GIE stack
    set_state(N'(1) << (3 + NS), msk, 1'b1);
    for (int i = 0; i < DEPTH; i++) begin
      take(); gie_write(1'b1); cyc();
    end
    chk("R12 no ovf at depth", int'(stk_ovf), 0);
    take();
    chk("R12 ovf set", int'(stk_ovf), 1);
    for (int i = 0; i < DEPTH; i++) give_back();
    chk("R11 gie after pops", int'(gie), 1);
    gie_write(1'b0);
    give_back();
    chk("R11 empty ret", int'(gie), 0);
    chk("R12 ovf sticky", int'(stk_ovf), 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule